// File: doc/BRIEF.md
# Half-Bridge Gate Interlock and Dead-Time Controller

This block sits between a PWM source and the two gate drivers of one half-bridge leg. It takes a high-side request that is active high and a low-side request that is active low, so one wire tied to both inputs gives complementary switching. It produces a high-side and a low-side gate enable. The block never lets both enables be high at once. When the two requests overlap it turns both sides off. At every handover it keeps both sides off for a programmed number of clock cycles.

An active-low shutdown input and two supply-good flags, one for each driver supply, gate the outputs. The supply flags are expected to come from undervoltage detectors that already apply hysteresis, and the block uses them as they arrive. The command inputs are asynchronous and pass through a synchronizer. The shutdown input and the supply flags act on the output registers directly. The reset is asynchronous and is released in step with the clock.

Top module: `hb_gate_ctrl`

## Requirements
- R1: While `halt_n` is sampled low at a clock edge, both gate enables are low after that edge, whatever the commands are.
- R2: With `halt_n` high and both supplies good, `hs_cmd`=0 together with `ls_cmd_n`=0 requests the low side only. `ls_gate` goes high and `hs_gate` stays low. The normal latency is 3 clock edges from the command change.
- R3: With `halt_n` high and both supplies good, `hs_cmd`=1 together with `ls_cmd_n`=1 requests the high side only. `hs_gate` goes high and `ls_gate` stays low.
- R4: `hs_cmd`=1 with `ls_cmd_n`=0 (overlap) drives both enables low, and so does `hs_cmd`=0 with `ls_cmd_n`=1 (no request).
- R5: `hs_gate` and `ls_gate` are never high in the same cycle.
- R6: After either enable falls, neither enable may rise until both have been low for max(D,1) cycles. D is the value of `dt_cycles` at the edge where the enable falls. The rule applies the same way to the low-to-high handover and to the high-to-low handover.
- R7: If the other side has already been off for at least the dead time, a new request takes effect at the normal 3-edge latency, with no added delay.
- R8: While an overlap is seen by the logic, the dead-time counter is held reloaded. After the overlap ends, the requested side turns on exactly D cycles later than the normal latency, measured from the command change that ends the overlap.
- R9: While `lo_sup_ok` is sampled low, both enables are low after that edge.
- R10: While `hi_sup_ok` is sampled low, `hs_gate` is low after that edge. The low side still follows its own request.
- R11: During reset both enables are low and the dead-time counter is expired, so the first request after reset sees the normal latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low, released synchronously |
| hs_cmd | input | 1 | High-side request, active high |
| ls_cmd_n | input | 1 | Low-side request, active low |
| halt_n | input | 1 | Shutdown, active low |
| dt_cycles | input | DT_W | Dead time in clock cycles |
| lo_sup_ok | input | 1 | Low-side supply good |
| hi_sup_ok | input | 1 | High-side supply good |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |

## Verification
A command change reaches the gate enables after 3 clock edges: two synchronizer flops, then the output register. A handover adds max(D,1) edges on top of that, and an overlap that ends adds D. Shutdown and the supply flags act after a single edge. The bench drives every input just after a falling edge. It then counts falling edges until the watched enable rises and compares that count with the value worked out from these latencies. Steady-state truth-table vectors are checked only after ten cycles, so their results no longer depend on what came before.

// File: rtl/hb_pkg.sv
package hb_pkg;

  // Decoded request after synchronization.
  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_LO   = 2'd1,
    REQ_HI   = 2'd2,
    REQ_BOTH = 2'd3
  } req_e;

  // hs active high, lsn active low.
  function automatic req_e decode_req(input logic hs, input logic lsn);
    return req_e'({hs, ~lsn});
  endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int             W       = 2,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= RST_VAL;
        else        stage_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/hb_dt_timer.sv
module hb_dt_timer #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,    // an enable fell this edge
  input  logic            hold,     // overlap seen: keep reloading
  input  logic [DT_W-1:0] dt,
  output logic            expired
);

  localparam logic [DT_W-1:0] ONE = DT_W'(1);

  logic [DT_W-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (start) begin
      // Gap of max(dt,1): the turn-off cycle counts as one.
      cnt_d  = (dt == '0) ? '0 : dt - ONE;
      cnt_en = 1'b1;
    end else if (hold) begin
      cnt_d  = dt;
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - ONE;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/hb_steer.sv
module hb_steer
  import hb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  req_e req,
  input  logic halt_n,
  input  logic lo_ok,
  input  logic hi_ok,
  input  logic dt_expired,
  output logic hs_gate,
  output logic ls_gate,
  output logic fall,
  output logic overlap
);

  logic hs_q, ls_q, hs_d, ls_d, gate_en;
  logic want_hi, want_lo;

  always_comb begin
    want_hi = (req == REQ_HI) && halt_n && lo_ok && hi_ok;
    want_lo = (req == REQ_LO) && halt_n && lo_ok;
    // Stay on while requested; turn on only when the other side is off
    // and the dead time has run out.
    hs_d    = want_hi && (hs_q || (!ls_q && dt_expired));
    ls_d    = want_lo && (ls_q || (!hs_q && dt_expired));
    gate_en = (hs_d != hs_q) || (ls_d != ls_q);
    fall    = (hs_q && !hs_d) || (ls_q && !ls_d);
    overlap = (req == REQ_BOTH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      ls_q <= 1'b0;
    end else if (gate_en) begin
      hs_q <= hs_d;
      ls_q <= ls_d;
    end
  end

  assign hs_gate = hs_q;
  assign ls_gate = ls_q;

endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hb_pkg::*;
#(
  parameter int DT_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hs_cmd,
  input  logic            ls_cmd_n,
  input  logic            halt_n,
  input  logic [DT_W-1:0] dt_cycles,
  input  logic            lo_sup_ok,
  input  logic            hi_sup_ok,
  output logic            hs_gate,
  output logic            ls_gate
);

  localparam int CMD_W = 2;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe_q;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign arst_n = rst_pipe_q[1];

  // Command synchronizer; reset value means "no request".
  logic [CMD_W-1:0] cmd_raw, cmd_s;
  assign cmd_raw = {ls_cmd_n, hs_cmd};

  hb_sync #(
    .W       (CMD_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (2'b10)
  ) u_sync (
    .clk   (clk),
    .rst_n (arst_n),
    .d     (cmd_raw),
    .q     (cmd_s)
  );

  req_e req;
  assign req = decode_req(cmd_s[0], cmd_s[1]);

  logic dt_expired, fall, overlap;

  hb_steer u_steer (
    .clk        (clk),
    .rst_n      (arst_n),
    .req        (req),
    .halt_n     (halt_n),
    .lo_ok      (lo_sup_ok),
    .hi_ok      (hi_sup_ok),
    .dt_expired (dt_expired),
    .hs_gate    (hs_gate),
    .ls_gate    (ls_gate),
    .fall       (fall),
    .overlap    (overlap)
  );

  hb_dt_timer #(
    .DT_W (DT_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (arst_n),
    .start   (fall),
    .hold    (overlap),
    .dt      (dt_cycles),
    .expired (dt_expired)
  );

endmodule

// File: rtl/hb_gate_ctrl_chk.sv
module hb_gate_ctrl_chk #(
  parameter int DT_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            halt_n,
  input logic            lo_sup_ok,
  input logic            hi_sup_ok,
  input logic [DT_W-1:0] dt_cycles,
  input logic [1:0]      req,
  input logic            hs_gate,
  input logic            ls_gate
);

  localparam int RUN_W = DT_W + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  // Cycles with both enables low, and the gap needed from the last fall.
  logic [RUN_W-1:0] off_run_q;
  logic [RUN_W-1:0] need_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_run_q <= RUN_MAX;
      need_q    <= RUN_W'(1);
    end else if (hs_gate || ls_gate) begin
      off_run_q <= '0;
      need_q    <= (dt_cycles == '0) ? RUN_W'(1) : RUN_W'(dt_cycles);
    end else if (off_run_q != RUN_MAX) begin
      off_run_q <= off_run_q + RUN_W'(1);
    end
  end

  a_r1_halt_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_n |=> (!hs_gate && !ls_gate));

  a_r4_overlap_off: assert property (@(posedge clk) disable iff (!rst_n)
    (req == hb_pkg::REQ_BOTH) |=> (!hs_gate && !ls_gate));

  a_r4_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
    (req == hb_pkg::REQ_NONE) |=> (!hs_gate && !ls_gate));

  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));

  a_r6_gap_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hs_gate) || $rose(ls_gate)) |-> (off_run_q >= need_q));

  a_r9_lo_supply_off: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_sup_ok |=> (!hs_gate && !ls_gate));

  a_r10_hi_supply_off: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_sup_ok |=> !hs_gate);

endmodule

bind hb_gate_ctrl hb_gate_ctrl_chk #(.DT_W(DT_W)) u_chk (
  .clk       (clk),
  .rst_n     (arst_n),
  .halt_n    (halt_n),
  .lo_sup_ok (lo_sup_ok),
  .hi_sup_ok (hi_sup_ok),
  .dt_cycles (dt_cycles),
  .req       (req),
  .hs_gate   (hs_gate),
  .ls_gate   (ls_gate)
);

// File: tb/tb_hb_gate_ctrl.sv
module tb_hb_gate_ctrl;

  localparam int CLK_P = 10;
  localparam int DT_W  = 8;
  localparam int NVEC  = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            hs_cmd = 1'b0;
  logic            ls_cmd_n = 1'b1;
  logic            halt_n = 1'b1;
  logic [DT_W-1:0] dt_cycles = 8'd2;
  logic            lo_sup_ok = 1'b1;
  logic            hi_sup_ok = 1'b1;
  logic            hs_gate, ls_gate;

  int n_chk = 0;
  int n_fail = 0;
  int both_hi = 0;
  int n = 0;

  always #(CLK_P/2) clk = ~clk;

  hb_gate_ctrl #(.DT_W(DT_W)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .hs_cmd    (hs_cmd),
    .ls_cmd_n  (ls_cmd_n),
    .halt_n    (halt_n),
    .dt_cycles (dt_cycles),
    .lo_sup_ok (lo_sup_ok),
    .hi_sup_ok (hi_sup_ok),
    .hs_gate   (hs_gate),
    .ls_gate   (ls_gate)
  );

  // {halt_n, lo_ok, hi_ok, hs_cmd, ls_cmd_n, exp_hs, exp_ls}
  localparam logic [6:0] VEC [NVEC] = '{
    7'b1110001, 7'b1111110, 7'b1111000, 7'b1110100,
    7'b0111100, 7'b0110000, 7'b1010000, 7'b1011100,
    7'b1101100, 7'b1100001, 7'b1111110, 7'b1110001
  };
  localparam int VREQ [NVEC] = '{2, 3, 4, 4, 1, 1, 9, 9, 10, 10, 3, 2};

  always @(negedge clk) if (rst_n && hs_gate && ls_gate) both_hi++;

  task automatic chk_pair(input logic eh, input logic el, input string tag);
    n_chk++;
    if (hs_gate !== eh || ls_gate !== el) begin
      n_fail++;
      $display("FAIL %s: hs/ls actual %b%b expected %b%b", tag, hs_gate, ls_gate, eh, el);
    end
  endtask

  task automatic chk_int(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Change commands after a falling edge, then count falling edges until
  // the watched enable is high.
  task automatic step(input logic h, input logic l, input bit watch_hi, output int cnt);
    @(negedge clk);
    hs_cmd   = h;
    ls_cmd_n = l;
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      cnt++;
      if (watch_hi ? hs_gate : ls_gate) break;
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R5 watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    chk_pair(1'b0, 1'b0, "R11 reset outputs");
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R11 / R2: first request after reset has normal latency
    step(1'b0, 1'b0, 1'b0, n);
    chk_int(n, 3, "R11 first low request latency");

    // R6: handovers with one wire driving both inputs, D=5
    dt_cycles = 8'd5;
    step(1'b1, 1'b1, 1'b1, n);
    chk_int(n, 8, "R6 low-to-high handover");
    step(1'b0, 1'b0, 1'b0, n);
    chk_int(n, 8, "R6 high-to-low handover matches");

    // R6: zero dead time still leaves one off cycle
    dt_cycles = 8'd0;
    step(1'b1, 1'b1, 1'b1, n);
    chk_int(n, 4, "R6 zero count minimum gap");

    // R7: long idle gap, direct drive
    dt_cycles = 8'd5;
    @(negedge clk);
    hs_cmd = 1'b0; ls_cmd_n = 1'b1;
    repeat (12) @(negedge clk);
    chk_pair(1'b0, 1'b0, "R4 idle both off");
    step(1'b0, 1'b0, 1'b0, n);
    chk_int(n, 3, "R7 direct drive after long gap");

    // R8: overlap holds the counter, D=4
    dt_cycles = 8'd4;
    step(1'b1, 1'b1, 1'b1, n);
    chk_int(n, 7, "R6 handover with D=4");
    @(negedge clk);
    hs_cmd = 1'b1; ls_cmd_n = 1'b0;
    repeat (10) @(negedge clk);
    chk_pair(1'b0, 1'b0, "R4 overlap both off");
    step(1'b0, 1'b0, 1'b0, n);
    chk_int(n, 7, "R8 turn-on after overlap ends");

    // R1: shutdown takes one edge
    @(negedge clk);
    halt_n = 1'b0;
    @(negedge clk);
    chk_pair(1'b0, 1'b0, "R1 shutdown one edge");
    halt_n = 1'b1;
    repeat (10) @(negedge clk);
    chk_pair(1'b0, 1'b1, "R2 low side back after shutdown");

    // R9: low supply bad
    lo_sup_ok = 1'b0;
    @(negedge clk);
    chk_pair(1'b0, 1'b0, "R9 low supply one edge");
    lo_sup_ok = 1'b1;
    repeat (10) @(negedge clk);

    // R10: high supply bad
    step(1'b1, 1'b1, 1'b1, n);
    chk_pair(1'b1, 1'b0, "R3 high side on");
    hi_sup_ok = 1'b0;
    @(negedge clk);
    chk_pair(1'b0, 1'b0, "R10 high supply one edge");
    hi_sup_ok = 1'b1;
    repeat (10) @(negedge clk);

    // Steady-state vector table, D=2
    dt_cycles = 8'd2;
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      {halt_n, lo_sup_ok, hi_sup_ok, hs_cmd, ls_cmd_n} = VEC[v][6:2];
      repeat (10) @(negedge clk);
      n_chk++;
      if (hs_gate !== VEC[v][1] || ls_gate !== VEC[v][0]) begin
        n_fail++;
        $display("FAIL R%0d vector %0d: hs/ls actual %b%b expected %b%b",
                 VREQ[v], v, hs_gate, ls_gate, VEC[v][1], VEC[v][0]);
      end
    end

    // R5: exclusive outputs over the whole run
    chk_int(both_hi, 0, "R5 cycles with both enables high");

    finish_run();
  end

endmodule